// File: doc/BRIEF.md
# Buck Switch Protection Sequencer

This block decides, one switching cycle at a time, which power switch of a synchronous buck stage may conduct. A cycle-start pulse opens each switching period. A level request from the modulator asks for high-side on-time. Digital comparator flags report four current conditions: the inductor current is below the valley limit, the current is above the peak limit, the current is more negative than the negative limit, and the current has crossed zero. The block turns these into two gate enables. It never lets both enables be high at once, and it inserts a dead time whenever conduction passes from one switch to the other.

Three protections act on the enables. Valley-limit skipping refuses to start a cycle while the current is still above the valley limit and keeps the low side conducting instead. The peak limit cuts the high-side on-time short, one cycle at a time, with no frequency foldback. The low-side cutoff depends on the mode: in forced-PWM mode it reacts to the negative-limit flag, and in automatic mode it reacts to the zero crossing, which lets the stage enter discontinuous conduction. A hiccup sequencer counts overloaded cycle starts. When the count completes, it turns both switches off for a parameterised number of clock ticks and then starts a fresh count.

Top module: `buck_prot_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `hs_en`, `ls_en` and `hiccup_active` are 0, and the overload count is zero.
- R2: A `cyc_start` pulse with `valley_ok`=1, `on_req`=1 and `peak_trip`=0 requests the high side. `hs_en` stays 1 until `on_req` falls or `peak_trip` rises, and the low side then takes over after the dead time.
- R3: At a `cyc_start` with `valley_ok`=0 (current still above the valley limit), the high side is not turned on and the low side stays on. A high-side period begins only at a later `cyc_start` that sees `valley_ok`=1.
- R4: `peak_trip`=1 in any cycle forces `hs_en`=0 after the next clock edge, including when it coincides with `cyc_start`. The high side does not return before the next `cyc_start`.
- R5: With `mode_fpwm`=1 (forced PWM), `neg_trip`=1 turns `ls_en` off at the next edge and keeps it off until the next `cyc_start`. `zero_cross` has no effect in this mode.
- R6: With `mode_fpwm`=0 (automatic), `zero_cross`=1 turns `ls_en` off at the next edge and keeps it off until the next `cyc_start`. `neg_trip` has no effect in this mode.
- R7: `hs_en` and `ls_en` are never both 1. After either enable falls, both stay 0 for at least DEAD_TICKS sampled cycles before either rises.
- R8: Each `cyc_start` outside hiccup with `valley_ok`=0 adds one to the overload count. The start that would make the count OVL_LIMIT (64) enters hiccup instead. A single clean start (`valley_ok`=1) leaves the count unchanged. A second consecutive clean start clears it.
- R9: In hiccup, `hiccup_active`=1 for exactly HICCUP_TICKS cycles, both enables are 0, and `cyc_start` is ignored. Afterwards both enables stay 0 until the next `cyc_start`, and the overload count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock pulse opening a switching cycle |
| on_req | input | 1 | Modulator request for high-side on-time (level) |
| mode_fpwm | input | 1 | 1 = forced PWM, 0 = automatic mode |
| valley_ok | input | 1 | 1 = inductor current below the valley limit |
| peak_trip | input | 1 | 1 = inductor current above the peak limit |
| neg_trip | input | 1 | 1 = negative current beyond the negative limit |
| zero_cross | input | 1 | 1 = inductor current has reached zero |
| hs_en | output | 1 | High-side switch enable |
| ls_en | output | 1 | Low-side switch enable |
| hiccup_active | output | 1 | 1 while the hiccup off interval runs |

## Verification
Two collisions matter. A cycle start can arrive in the same clock as a peak-limit trip, and the cycle start that completes the overload count must open hiccup rather than another skipped cycle. The bench drives the first collision directly, with `cyc_start` and `peak_trip` raised together while the high side conducts, and expects `hs_en` to be low after that edge. For the second, a bench model of the count predicts which start must raise `hiccup_active`, and the bench checks that both enables fall in that same cycle. A random phase then mixes all flags and modes and checks that the enables are exclusive, that dead time is respected, and that every peak trip cuts the high side.

// File: rtl/buck_prot_pkg.sv
package buck_prot_pkg;

    // Switching phase of the sequencer
    typedef enum logic [2:0] {
        PH_IDLE,     // both off, waiting for a cycle start
        PH_HIGH,     // high-side on-time
        PH_LOW,      // low-side freewheel (also valley-skip hold)
        PH_LOWOFF,   // low side cut off until the next cycle start
        PH_HICCUP    // overload off interval
    } phase_e;

    // Switch the phase asks the gate stage for
    typedef enum logic [1:0] {
        SW_NONE,
        SW_HIGH,
        SW_LOW
    } sw_req_e;

    // Comparator flags bundled as one sample
    typedef struct packed {
        logic valley_ok;
        logic peak_trip;
        logic neg_trip;
        logic zero_cross;
    } sense_t;

    function automatic sw_req_e phase_to_req(phase_e p);
        sw_req_e r;
        case (p)
            PH_HIGH: r = SW_HIGH;
            PH_LOW:  r = SW_LOW;
            default: r = SW_NONE;
        endcase
        return r;
    endfunction

    // Low-side cutoff condition selected by the operating mode
    function automatic logic low_cut(logic fpwm, sense_t s);
        return fpwm ? s.neg_trip : s.zero_cross;
    endfunction

endpackage

// File: rtl/bps_ovl_counter.sv
module bps_ovl_counter #(
    parameter int OVL_LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic eval,       // qualified cycle start
    input  logic valley_ok,
    output logic trip
);
    localparam int CW = $clog2(OVL_LIMIT + 1);

    logic [CW-1:0] cnt_q;
    logic [1:0]    clean_q;

    assign trip = eval && !valley_ok && (cnt_q == CW'(OVL_LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            clean_q <= '0;
        end else if (eval) begin
            if (!valley_ok) begin
                clean_q <= '0;
                cnt_q   <= trip ? '0 : cnt_q + 1'b1;
            end else begin
                if (clean_q != 2'd0) cnt_q <= '0;
                if (clean_q != 2'd2) clean_q <= clean_q + 1'b1;
            end
        end
    end

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(OVL_LIMIT));

    assert_single_clean_R8: assert property (@(posedge clk) disable iff (rst)
        (eval && valley_ok && clean_q == 2'd0) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/bps_hiccup_timer.sv
module bps_hiccup_timer #(
    parameter int HICCUP_TICKS = 1_100_000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active,
    output logic last
);
    localparam int TW = $clog2(HICCUP_TICKS + 1);

    logic [TW-1:0] rem_q;
    logic          act_q;

    assign active = act_q;
    assign last   = act_q && (rem_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            rem_q <= '0;
        end else if (start) begin
            act_q <= 1'b1;
            rem_q <= TW'(HICCUP_TICKS - 1);
        end else if (act_q) begin
            if (rem_q == '0) act_q <= 1'b0;
            else             rem_q <= rem_q - 1'b1;
        end
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (act_q && rem_q != '0) |=> act_q);

endmodule

// File: rtl/bps_phase_fsm.sv
module bps_phase_fsm
    import buck_prot_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cyc_start,
    input  logic    on_req,
    input  logic    mode_fpwm,
    input  sense_t  sense,
    input  logic    ovl_trip,
    input  logic    hic_last,
    output logic    eval,
    output sw_req_e req
);
    phase_e ph_q, ph_d;

    // cycle starts are only judged outside the hiccup interval
    assign eval = cyc_start && (ph_q != PH_HICCUP);

    always_comb begin
        ph_d = ph_q;
        if (ph_q == PH_HICCUP) begin
            if (hic_last) ph_d = PH_IDLE;
        end else if (cyc_start) begin
            if (ovl_trip)                           ph_d = PH_HICCUP;
            else if (!sense.valley_ok)              ph_d = PH_LOW;
            else if (on_req && !sense.peak_trip)    ph_d = PH_HIGH;
            else                                    ph_d = PH_LOW;
        end else begin
            case (ph_q)
                PH_HIGH: if (sense.peak_trip || !on_req) ph_d = PH_LOW;
                PH_LOW:  if (sense.valley_ok && low_cut(mode_fpwm, sense)) ph_d = PH_LOWOFF;
                default: ph_d = ph_q;
            endcase
        end
    end

    assign req = phase_to_req(ph_d);

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_IDLE;
        else     ph_q <= ph_d;
    end

    assert_lowoff_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_LOWOFF && !cyc_start) |=> (ph_q == PH_LOWOFF));

    assert_hiccup_entry_R8: assert property (@(posedge clk) disable iff (rst)
        (ph_q != PH_HICCUP && ph_d == PH_HICCUP) |-> (cyc_start && !sense.valley_ok));

endmodule

// File: rtl/bps_gate_deadtime.sv
module bps_gate_deadtime
    import buck_prot_pkg::*;
#(
    parameter int DEAD_TICKS = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  sw_req_e req,
    output logic    hs_en,
    output logic    ls_en
);
    localparam int GW = $clog2(DEAD_TICKS + 1);

    logic          hs_q, ls_q;
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q  <= 1'b0;
            ls_q  <= 1'b0;
            gap_q <= GW'(DEAD_TICKS);
        end else if (hs_q && req != SW_HIGH) begin
            hs_q  <= 1'b0;
            gap_q <= GW'(1);
        end else if (ls_q && req != SW_LOW) begin
            ls_q  <= 1'b0;
            gap_q <= GW'(1);
        end else if (!hs_q && !ls_q) begin
            if (req != SW_NONE && gap_q >= GW'(DEAD_TICKS)) begin
                hs_q <= (req == SW_HIGH);
                ls_q <= (req == SW_LOW);
            end else if (gap_q < GW'(DEAD_TICKS)) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    assign hs_en = hs_q;
    assign ls_en = ls_q;

    assert_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(hs_q && ls_q));

    assert_ls_gap_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_q) |-> $past(!hs_q));

    assert_hs_gap_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_q) |-> $past(!ls_q));

endmodule

// File: rtl/buck_prot_seq.sv
module buck_prot_seq
    import buck_prot_pkg::*;
#(
    parameter int DEAD_TICKS   = 4,
    parameter int OVL_LIMIT    = 64,
    parameter int HICCUP_TICKS = 1_100_000
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_start,
    input  logic on_req,
    input  logic mode_fpwm,
    input  logic valley_ok,
    input  logic peak_trip,
    input  logic neg_trip,
    input  logic zero_cross,
    output logic hs_en,
    output logic ls_en,
    output logic hiccup_active
);
    sense_t  sense;
    sw_req_e req;
    logic    eval, ovl_trip, hic_last;

    assign sense = '{valley_ok: valley_ok, peak_trip: peak_trip,
                     neg_trip: neg_trip, zero_cross: zero_cross};

    bps_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cyc_start (cyc_start),
        .on_req    (on_req),
        .mode_fpwm (mode_fpwm),
        .sense     (sense),
        .ovl_trip  (ovl_trip),
        .hic_last  (hic_last),
        .eval      (eval),
        .req       (req)
    );

    bps_ovl_counter #(.OVL_LIMIT(OVL_LIMIT)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .eval      (eval),
        .valley_ok (valley_ok),
        .trip      (ovl_trip)
    );

    bps_hiccup_timer #(.HICCUP_TICKS(HICCUP_TICKS)) u_hic (
        .clk    (clk),
        .rst    (rst),
        .start  (ovl_trip),
        .active (hiccup_active),
        .last   (hic_last)
    );

    bps_gate_deadtime #(.DEAD_TICKS(DEAD_TICKS)) u_gate (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .hs_en (hs_en),
        .ls_en (ls_en)
    );

    assert_peak_cut_R4: assert property (@(posedge clk) disable iff (rst)
        peak_trip |=> !hs_en);

    assert_valley_skip_R3: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && !valley_ok) |=> !hs_en);

    assert_hiccup_off_R9: assert property (@(posedge clk) disable iff (rst)
        hiccup_active |-> (!hs_en && !ls_en));

endmodule

// File: tb/buck_prot_seq_tb.sv
module buck_prot_seq_tb;
    localparam int DEAD = 2;
    localparam int OVL  = 64;
    localparam int HIC  = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc_start = 0, on_req = 0, mode_fpwm = 1, valley_ok = 1;
    logic peak_trip = 0, neg_trip = 0, zero_cross = 0;
    logic hs_en, ls_en, hiccup_active;

    int compared = 0;
    int mismatched = 0;
    int m_cnt = 0, m_clean = 0;
    bit m_hic = 0;

    always #2.5 clk = ~clk;

    buck_prot_seq #(.DEAD_TICKS(DEAD), .OVL_LIMIT(OVL), .HICCUP_TICKS(HIC)) u_dut (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .on_req(on_req),
        .mode_fpwm(mode_fpwm), .valley_ok(valley_ok), .peak_trip(peak_trip),
        .neg_trip(neg_trip), .zero_cross(zero_cross),
        .hs_en(hs_en), .ls_en(ls_en), .hiccup_active(hiccup_active)
    );

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    task automatic chk(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Requirement-level model of the overload count (R8): returns expected trip
    function automatic bit ovl_model(bit bad);
        bit t = 0;
        if (bad) begin
            m_clean = 0;
            if (m_cnt == OVL - 1) begin t = 1; m_cnt = 0; end
            else m_cnt++;
        end else begin
            if (m_clean >= 1) m_cnt = 0;
            if (m_clean < 2) m_clean++;
        end
        return t;
    endfunction

    // One cycle start; checks the predicted hiccup entry (R8)
    task automatic start_cycle();
        if (ovl_model(!valley_ok)) m_hic = 1;
        cyc_start = 1;
        step();
        cyc_start = 0;
        chk("R8", hiccup_active, m_hic);
    endtask

    task automatic run_starts(int n);
        for (int i = 0; i < n; i++) begin
            start_cycle();
            step(3);
        end
    endtask

    task automatic wait_hiccup();
        int n = 1;
        while (hiccup_active && n < 200) begin
            chk("R9", hs_en | ls_en, 0);
            if (n == 5) cyc_start = 1;
            step();
            cyc_start = 0;
            if (hiccup_active) n++;
        end
        chk("R9", n, HIC);
        m_hic = 0;
        step(3);
        chk("R9", hs_en | ls_en, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog act=running exp=finished");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0d17));
        // R1 reset
        step(3);
        chk("R1", hs_en, 0); chk("R1", ls_en, 0); chk("R1", hiccup_active, 0);
        rst = 0;
        step();
        chk("R1", hs_en | ls_en | hiccup_active, 0);

        // R2 high side
        mode_fpwm = 1; valley_ok = 1; on_req = 1;
        start_cycle();
        chk("R2", hs_en, 1); chk("R2", ls_en, 0);
        step(3);
        chk("R2", hs_en, 1);

        // R4 peak cut, R7 dead time
        peak_trip = 1; step(); peak_trip = 0;
        chk("R4", hs_en, 0); chk("R7", ls_en, 0);
        step(); chk("R7", ls_en, 0);
        step(); chk("R4", ls_en, 1);
        step(3); chk("R4", hs_en, 0);

        // R5 forced PWM: zero cross ignored, negative trip cuts low side
        zero_cross = 1; step(2); chk("R5", ls_en, 1); zero_cross = 0;
        neg_trip = 1; step(); neg_trip = 0;
        chk("R5", ls_en, 0);
        step(4); chk("R5", ls_en | hs_en, 0);

        // R2 end of on-time by request
        start_cycle();
        chk("R2", hs_en, 1);
        on_req = 0; step(); chk("R2", hs_en, 0);
        step(2); chk("R2", ls_en, 1);

        // R6 automatic mode
        mode_fpwm = 0;
        neg_trip = 1; step(2); chk("R6", ls_en, 1); neg_trip = 0;
        zero_cross = 1; step(); zero_cross = 0;
        chk("R6", ls_en, 0);
        step(3); chk("R6", ls_en | hs_en, 0);

        // R3 valley skipping
        start_cycle(); chk("R3", ls_en, 1);
        step(2);
        valley_ok = 0; on_req = 1;
        start_cycle(); chk("R3", hs_en, 0); chk("R3", ls_en, 1);
        step(5); chk("R3", hs_en, 0); chk("R3", ls_en, 1);
        valley_ok = 1; step(3); chk("R3", hs_en, 0);
        start_cycle(); chk("R3", hs_en | ls_en, 0);
        step(); chk("R7", hs_en, 0);
        step(); chk("R3", hs_en, 1);

        // R4 collision of peak trip with a cycle start
        peak_trip = 1; start_cycle(); peak_trip = 0;
        chk("R4", hs_en, 0);
        step(4);

        // R8 single clean start does not clear the count
        mode_fpwm = 1; on_req = 0; valley_ok = 1;
        run_starts(2);
        valley_ok = 0; run_starts(OVL - 1);
        valley_ok = 1; run_starts(1);
        valley_ok = 0; start_cycle();
        chk("R8", hiccup_active, 1);
        wait_hiccup();

        // R9 fresh count after hiccup, R8 two clean starts clear it
        run_starts(OVL - 1);
        valley_ok = 1; run_starts(2);
        valley_ok = 0; run_starts(1);
        chk("R8", hiccup_active, 0);
        run_starts(OVL - 2);
        start_cycle();
        chk("R8", hiccup_active, 1);
        wait_hiccup();

        // Random phase: R7 exclusion and dead time, R4 peak cut, R9 off
        rst = 1; step(2); rst = 0;
        begin
            int  run = DEAD;
            bit  prev_on = 0, prev_peak = 0;
            for (int k = 0; k < 4000; k++) begin
                cyc_start  = ($urandom_range(7) == 0);
                on_req     = ($urandom_range(3) != 0);
                valley_ok  = ($urandom_range(4) != 0);
                peak_trip  = ($urandom_range(9) == 0);
                neg_trip   = ($urandom_range(9) == 0);
                zero_cross = ($urandom_range(9) == 0);
                if ($urandom_range(99) == 0) mode_fpwm = ~mode_fpwm;
                prev_peak = peak_trip;
                step();
                chk("R7", hs_en & ls_en, 0);
                if (prev_peak) chk("R4", hs_en, 0);
                if (hiccup_active) chk("R9", hs_en | ls_en, 0);
                if (hs_en || ls_en) begin
                    if (!prev_on) chk("R7", (run >= DEAD) ? 1 : 0, 1);
                    run = 0;
                    prev_on = 1;
                end else begin
                    run++;
                    prev_on = 0;
                end
            end
        end
        cyc_start = 0;
        report();
        $finish;
    end
endmodule